// File: doc/BRIEF.md
# BCD Adjust Unit

This unit repairs the accumulator byte after a binary addition or subtraction whose operands were decimal digits. It is given the low accumulator byte, the high accumulator byte, the carry and auxiliary-carry flags left by the preceding arithmetic, and a 2-bit operation code. From these it produces the corrected bytes and the new flags. Two families of correction are supported. The packed forms hold two decimal digits per byte. The unpacked forms hold one digit per byte and carry into or borrow from the high byte.

The unit is fed with a one-cycle input strobe. The result appears on registered outputs one clock later, together with an output strobe. The outputs then hold until the next strobe. The digit width, the radix and the parity sense are parameters. Their defaults give 4-bit nibbles, radix 10 and even parity.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset every output is 0. An `in_valid` pulse sampled at a rising edge makes `out_valid` 1 after that edge and loads all result outputs at that edge. A cycle without `in_valid` gives `out_valid` 0 and leaves all result outputs unchanged.
- R2: `op_i` selects the correction as follows: 0 is packed add, 1 is packed subtract, 2 is unpacked add and 3 is unpacked subtract.
- R3: For the packed forms, the low-digit fix applies when `al_in[3:0]` is greater than 9 or `af_in` is 1. The fix adds 06h (op 0) or subtracts 06h (op 1), modulo 256, and `af_out` reports whether the fix applied.
- R4: For the packed forms, the high-digit fix applies when the original `al_in` is greater than 99h or `cf_in` is 1, whatever the low-digit fix did. The fix adds 60h (op 0) or subtracts 60h (op 1) on top of any low-digit fix, and `cf_out` reports whether the fix applied.
- R5: For the packed forms, `ah_out` equals `ah_in`.
- R6: For the unpacked forms, the fix applies when `al_in[3:0]` is greater than 9 or `af_in` is 1. When it applies, AL gets 6 added (op 2) or subtracted (op 3), `ah_out` is `ah_in`+1 (op 2) or `ah_in`-1 (op 3) modulo 256, and `cf_out` and `af_out` are both 1. When it does not apply, AH is unchanged and both flags are 0.
- R7: For the unpacked forms, `al_out[7:4]` is always 0, whether or not the fix applied.
- R8: For the packed forms, `zf_out` is 1 when the final AL is 0, `sf_out` is bit 7 of the final AL, and `pf_out` is 1 when the final AL has an even number of 1 bits. For the unpacked forms all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| op_i | input | 2 | Correction select |
| al_in | input | 8 | Low accumulator byte |
| ah_in | input | 8 | High accumulator byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| out_valid | output | 1 | Result strobe |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry flag after correction |
| af_out | output | 1 | Auxiliary-carry flag after correction |
| zf_out | output | 1 | Zero flag (packed forms) |
| sf_out | output | 1 | Sign flag (packed forms) |
| pf_out | output | 1 | Parity flag (packed forms) |

## Verification
The unit has no state that outlives one operation other than the result register. A bad digit decision therefore shows up on the very next output strobe, as an AL off by 06h or 60h with a matching wrong flag. The hardest cases are the ones where the two decisions interact: AL values just above 99h, values whose low-digit fix carries into the high digit, and incoming flags set while the digits themselves are in range. A result register that fails to hold would show as changed outputs in a cycle with no strobe.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
   typedef enum logic [1:0] {
      ADJ_PK_ADD = 2'd0,
      ADJ_PK_SUB = 2'd1,
      ADJ_UP_ADD = 2'd2,
      ADJ_UP_SUB = 2'd3
   } adj_op_e;
endpackage

// File: rtl/bcd_digit_judge.sv
module bcd_digit_judge #(
   parameter int NIB_W = 4,
   parameter int RADIX = 10
) (
   input  logic [2*NIB_W-1:0] byte_i,
   input  logic               aux_i,
   input  logic               carry_i,
   output logic               low_fix_o,
   output logic               high_fix_o
);
   localparam int BYTE_W = 2 * NIB_W;
   localparam logic [NIB_W-1:0]  LIM_N = NIB_W'(RADIX - 1);
   localparam logic [BYTE_W-1:0] LIM_B = {LIM_N, LIM_N};

   // The high decision looks at the untouched byte, so the low fix cannot sway it.
   always_comb begin
      low_fix_o  = (byte_i[NIB_W-1:0] > LIM_N) | aux_i;
      high_fix_o = (byte_i > LIM_B) | carry_i;
   end
endmodule

// File: rtl/bcd_packed_path.sv
module bcd_packed_path #(
   parameter int NIB_W = 4,
   parameter int RADIX = 10
) (
   input  logic [2*NIB_W-1:0] byte_i,
   input  logic               low_fix_i,
   input  logic               high_fix_i,
   input  logic               sub_i,
   output logic [2*NIB_W-1:0] byte_o
);
   localparam int BYTE_W = 2 * NIB_W;
   localparam logic [BYTE_W-1:0] FIX_LO = BYTE_W'((2 ** NIB_W) - RADIX);
   localparam logic [BYTE_W-1:0] FIX_HI = FIX_LO << NIB_W;

   logic [BYTE_W-1:0] corr;

   always_comb begin
      corr   = (low_fix_i ? FIX_LO : '0) | (high_fix_i ? FIX_HI : '0);
      byte_o = sub_i ? (byte_i - corr) : (byte_i + corr);
   end
endmodule

// File: rtl/bcd_unpacked_path.sv
module bcd_unpacked_path #(
   parameter int NIB_W = 4,
   parameter int RADIX = 10
) (
   input  logic [2*NIB_W-1:0] lo_i,
   input  logic [2*NIB_W-1:0] hi_i,
   input  logic               fix_i,
   input  logic               sub_i,
   output logic [2*NIB_W-1:0] lo_o,
   output logic [2*NIB_W-1:0] hi_o
);
   localparam int BYTE_W = 2 * NIB_W;
   localparam logic [BYTE_W-1:0] FIX_LO = BYTE_W'((2 ** NIB_W) - RADIX);
   localparam logic [BYTE_W-1:0] ONE    = BYTE_W'(1);

   logic [BYTE_W-1:0] lo_adj;

   always_comb begin
      if (!fix_i)     lo_adj = lo_i;
      else if (sub_i) lo_adj = lo_i - FIX_LO;
      else            lo_adj = lo_i + FIX_LO;
      // The upper digit of the low byte is always dropped.
      lo_o = {{NIB_W{1'b0}}, lo_adj[NIB_W-1:0]};
      if (!fix_i)     hi_o = hi_i;
      else if (sub_i) hi_o = hi_i - ONE;
      else            hi_o = hi_i + ONE;
   end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen #(
   parameter int BYTE_W  = 8,
   parameter bit PF_EVEN = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              zf_o,
   output logic              sf_o,
   output logic              pf_o
);
   assign zf_o = (byte_i == '0);
   assign sf_o = byte_i[BYTE_W-1];

   if (PF_EVEN) begin : g_pf_even
      assign pf_o = ~(^byte_i);
   end else begin : g_pf_odd
      assign pf_o = ^byte_i;
   end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
   import bcd_adj_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int RADIX   = 10,
   parameter bit PF_EVEN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           op_i,
   input  logic [2*NIB_W-1:0]   al_in,
   input  logic [2*NIB_W-1:0]   ah_in,
   input  logic                 cf_in,
   input  logic                 af_in,
   output logic                 out_valid,
   output logic [2*NIB_W-1:0]   al_out,
   output logic [2*NIB_W-1:0]   ah_out,
   output logic                 cf_out,
   output logic                 af_out,
   output logic                 zf_out,
   output logic                 sf_out,
   output logic                 pf_out
);
   localparam int BYTE_W = 2 * NIB_W;

   if (NIB_W < 2) begin : g_bad_nib
      $error("bcd_adjust_unit: NIB_W must be at least 2");
   end
   if (RADIX < 2 || RADIX > (2 ** NIB_W)) begin : g_bad_radix
      $error("bcd_adjust_unit: RADIX must lie in 2 .. 2**NIB_W");
   end

   adj_op_e op;
   logic    unpk, sub;
   logic    low_fix, high_fix;
   logic [BYTE_W-1:0] pk_al, up_al, up_ah;
   logic [BYTE_W-1:0] nx_al, nx_ah;
   logic    nx_cf, nx_af;
   logic    pk_zf, pk_sf, pk_pf;

   always_comb begin
      op   = adj_op_e'(op_i);
      unpk = (op == ADJ_UP_ADD) || (op == ADJ_UP_SUB);
      sub  = (op == ADJ_PK_SUB) || (op == ADJ_UP_SUB);
   end

   bcd_digit_judge #(.NIB_W(NIB_W), .RADIX(RADIX)) u_judge (
      .byte_i     (al_in),
      .aux_i      (af_in),
      .carry_i    (cf_in),
      .low_fix_o  (low_fix),
      .high_fix_o (high_fix)
   );

   bcd_packed_path #(.NIB_W(NIB_W), .RADIX(RADIX)) u_packed (
      .byte_i     (al_in),
      .low_fix_i  (low_fix),
      .high_fix_i (high_fix),
      .sub_i      (sub),
      .byte_o     (pk_al)
   );

   bcd_unpacked_path #(.NIB_W(NIB_W), .RADIX(RADIX)) u_unpacked (
      .lo_i  (al_in),
      .hi_i  (ah_in),
      .fix_i (low_fix),
      .sub_i (sub),
      .lo_o  (up_al),
      .hi_o  (up_ah)
   );

   bcd_flag_gen #(.BYTE_W(BYTE_W), .PF_EVEN(PF_EVEN)) u_flags (
      .byte_i (pk_al),
      .zf_o   (pk_zf),
      .sf_o   (pk_sf),
      .pf_o   (pk_pf)
   );

   always_comb begin
      if (unpk) begin
         nx_al = up_al;
         nx_ah = up_ah;
         nx_cf = low_fix;
         nx_af = low_fix;
      end else begin
         nx_al = pk_al;
         nx_ah = ah_in;
         nx_cf = high_fix;
         nx_af = low_fix;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         al_out    <= '0;
         ah_out    <= '0;
         cf_out    <= 1'b0;
         af_out    <= 1'b0;
         zf_out    <= 1'b0;
         sf_out    <= 1'b0;
         pf_out    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            al_out <= nx_al;
            ah_out <= nx_ah;
            cf_out <= nx_cf;
            af_out <= nx_af;
            zf_out <= unpk ? 1'b0 : pk_zf;
            sf_out <= unpk ? 1'b0 : pk_sf;
            pf_out <= unpk ? 1'b0 : pk_pf;
         end
      end
   end
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk #(
   parameter int NIB_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         op_i,
   input logic [2*NIB_W-1:0] ah_in,
   input logic               cf_in,
   input logic               af_in,
   input logic               out_valid,
   input logic [2*NIB_W-1:0] al_out,
   input logic [2*NIB_W-1:0] ah_out,
   input logic               cf_out,
   input logic               af_out,
   input logic               zf_out,
   input logic               sf_out,
   input logic               pf_out
);
   AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(al_out) && $stable(ah_out) && $stable(cf_out) && $stable(af_out))); // R1
   AST_PK_AUX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_i[1] && af_in) |=> af_out); // R3
   AST_PK_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_i[1] && cf_in) |=> cf_out); // R4
   AST_PK_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_i[1]) |=> (ah_out == $past(ah_in))); // R5
   AST_UP_FLAGS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_i[1]) |=> (cf_out == af_out)); // R6
   AST_UP_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_i[1]) |=> (al_out[2*NIB_W-1:NIB_W] == '0)); // R7
   AST_UP_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_i[1]) |=> (!zf_out && !sf_out && !pf_out)); // R8
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk #(.NIB_W(NIB_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_i      (op_i),
   .ah_in     (ah_in),
   .cf_in     (cf_in),
   .af_in     (af_in),
   .out_valid (out_valid),
   .al_out    (al_out),
   .ah_out    (ah_out),
   .cf_out    (cf_out),
   .af_out    (af_out),
   .zf_out    (zf_out),
   .sf_out    (sf_out),
   .pf_out    (pf_out)
);

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] op_i = 2'd0;
   logic [7:0] al_in = 8'h00, ah_in = 8'h00;
   logic       cf_in = 1'b0, af_in = 1'b0;
   logic       out_valid;
   logic [7:0] al_out, ah_out;
   logic       cf_out, af_out, zf_out, sf_out, pf_out;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bcd_adjust_unit u_bcd_adjust_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
      .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
      .out_valid(out_valid), .al_out(al_out), .ah_out(ah_out),
      .cf_out(cf_out), .af_out(af_out), .zf_out(zf_out),
      .sf_out(sf_out), .pf_out(pf_out)
   );

   // Expected result: {al, ah, cf, af, zf, sf, pf}
   function automatic logic [20:0] model(input logic [1:0] op, input logic [7:0] al,
                                         input logic [7:0] ah, input logic cf, input logic af);
      logic lo, hi;
      logic [7:0] ra, rh;
      logic rc, rf, z, s, p;
      lo = (al[3:0] > 4'd9) || af;
      hi = (al > 8'h99) || cf;
      if (op[1]) begin
         ra = al;
         rh = ah;
         if (lo) begin
            ra = op[0] ? al - 8'd6 : al + 8'd6;
            rh = op[0] ? ah - 8'd1 : ah + 8'd1;
         end
         ra = ra & 8'h0F;
         rc = lo; rf = lo; z = 0; s = 0; p = 0;
      end else begin
         ra = al;
         if (lo) ra = op[0] ? ra - 8'h06 : ra + 8'h06;
         if (hi) ra = op[0] ? ra - 8'h60 : ra + 8'h60;
         rh = ah; rc = hi; rf = lo;
         z = (ra == 8'h00);
         s = ra[7];
         p = ($countones(ra) % 2) == 0;
      end
      return {ra, rh, rc, rf, z, s, p};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [7:0] al, input logic [7:0] ah,
                         input logic cf, input logic af);
      logic [20:0] e;
      e = model(op, al, ah, cf, af);
      @(negedge clk);
      op_i = op; al_in = al; ah_in = ah; cf_in = cf; af_in = af; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 out_valid", int'(out_valid), 1);
      chk(op[1] ? "R6/R7 al" : "R3/R4 al", int'(al_out), int'(e[20:13]));
      chk(op[1] ? "R6 ah" : "R5 ah", int'(ah_out), int'(e[12:5]));
      chk(op[1] ? "R6 cf" : "R4 cf", int'(cf_out), int'(e[4]));
      chk(op[1] ? "R6 af" : "R3 af", int'(af_out), int'(e[3]));
      chk("R8 zf/sf/pf", int'({zf_out, sf_out, pf_out}), int'(e[2:0]));
   endtask

   task automatic hold_check();
      logic [20:0] prev;
      prev = {al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out};
      op_i = 2'($urandom); al_in = 8'($urandom); ah_in = 8'($urandom);
      cf_in = 1'($urandom); af_in = 1'($urandom);
      @(negedge clk);
      chk("R1 idle strobe", int'(out_valid), 0);
      chk("R1 idle hold", int'({al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out}), int'(prev));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      #35;
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset data", int'({al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out}), 0);
      rst_n = 1'b1;
      // R3 R4 directed corners
      run_op(2'd0, 8'h9A, 8'h11, 1'b0, 1'b0); // both fixes, result 00
      run_op(2'd0, 8'h99, 8'h00, 1'b0, 1'b0); // no fix at the limit
      run_op(2'd0, 8'h94, 8'h00, 1'b0, 1'b1); // aux only
      run_op(2'd0, 8'h3C, 8'h00, 1'b0, 1'b0); // low fix only
      run_op(2'd0, 8'h12, 8'h00, 1'b1, 1'b0); // carry only
      run_op(2'd1, 8'hFF, 8'h22, 1'b0, 1'b0); // subtract both
      run_op(2'd1, 8'h06, 8'h00, 1'b0, 1'b1); // subtract to zero
      run_op(2'd1, 8'h45, 8'h33, 1'b1, 1'b0);
      // R6 R7 directed corners
      run_op(2'd2, 8'h3F, 8'hFF, 1'b0, 1'b0); // AH wraps up
      run_op(2'd2, 8'h79, 8'h05, 1'b1, 1'b0); // no fix, top cleared
      run_op(2'd2, 8'h02, 8'h05, 1'b0, 1'b1);
      run_op(2'd3, 8'h05, 8'h00, 1'b0, 1'b1); // AH wraps down
      run_op(2'd3, 8'hEB, 8'h10, 1'b0, 1'b0);
      run_op(2'd3, 8'hA9, 8'h10, 1'b1, 1'b0);
      hold_check();
      // R2 random sweep over every operation
      for (int i = 0; i < 400; i++) begin
         run_op(2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
         if ((i % 37) == 0) hold_check();
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule